// File: doc/BRIEF.md
# Comma-Aligned Receive Byte Clock Generator

This block sits after the deserializer of an 8b/10b receiver. It takes one 10-bit word per word period, together with a valid strobe, and passes each word through a fixed-depth pipeline to a registered parallel output. It raises a comma flag whenever the word on that output is a comma and detection is enabled. It also generates two receive byte clocks, which a downstream device uses to capture the output words.

All logic runs on one internal clock `clk` at twice the word rate, so a word period (a "slot") is two `clk` cycles. The first slot begins with the first cycle after reset is released. Each following slot begins two cycles after the previous one. The input word is sampled at the clock edge that ends a slot. The byte clocks are registered levels in the `clk` domain.

With `splitRate` low, `clkOutP` is a word-rate clock: low in the first half of each slot and high in the second half. With `splitRate` high, `clkOutP` and `clkOutN` are complementary clocks at half the word rate, and each word is captured by one rising edge. The phase of these clocks is corrected by stretching only. When the next word is a comma that would otherwise meet a falling edge of `clkOutP`, both clocks hold their level for one extra word period. The comma then arrives on a rising edge of `clkOutP`. The data latency is not changed by this correction.

Top module: `rx_byteclk_gen`

## Requirements
- R1: While `rst` is high, and in the first half of the first slot after its release, `dataOut` is 0, `commaFlag` is 0, `clkOutP` is 0 and `clkOutN` is 1.
- R2: A word is a comma when its valid bit was set and its bits [6:0] equal 7'b1111100 or 7'b0000011 (bit 0 is the first bit received). `commaFlag` is 1 exactly when `commaDetEn` is 1 and the word on `dataOut` is a comma.
- R3: A word sampled at the end of slot j is shown on `dataOut` for the whole of slot j+PIPE_DEPTH (8 by default). The output is stable within a slot, and a clock stretch does not change this latency.
- R4: For a slot opened with `splitRate` low, `clkOutP` is 0 in the first half and 1 in the second half.
- R5: `clkOutN` is always the complement of `clkOutP`.
- R6: With `splitRate` high, `clkOutP` never changes at a slot boundary. At each slot midpoint it toggles, unless a stretch applies.
- R7: With `splitRate` high, a stretch holds `clkOutP` at the midpoint of slot n. It applies exactly when `clkOutP` is low there, the word of slot n+1 is a comma, and the word of slot n is not a comma.
- R8: If `splitRate` was high through slots n-1 and n, a comma in slot n that follows a non-comma sees `clkOutP` low in the first half of slot n and high in the second half.
- R9: Within a run of back-to-back commas, no stretch occurs after the first comma. `clkOutP` toggles in every slot and `commaFlag` stays high throughout, as long as `commaDetEn` stays high.
- R10: While `splitRate` stays high, each level of `clkOutP` lasts at least two `clk` cycles (one word period).
- R11: A change of `splitRate` made in the second half of slot n takes effect for slot n+1. A switch to the split scheme continues from the level `clkOutP` already has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the word rate |
| rst | input | 1 | Synchronous reset, active high |
| rxWord | input | 10 | Received word, sampled at the end of each slot |
| rxValid | input | 1 | Qualifies `rxWord` for comma detection |
| commaDetEn | input | 1 | Enables `commaFlag` |
| splitRate | input | 1 | 1: two complementary half-rate clocks; 0: one word-rate clock on `clkOutP` |
| dataOut | output | 10 | Pipelined word, one per slot |
| commaFlag | output | 1 | Comma present on `dataOut` while enabled |
| clkOutP | output | 1 | Byte clock that carries comma alignment |
| clkOutN | output | 1 | Complement of `clkOutP` |

## Verification
Two decisions can fall on the same slot midpoint: the stretch decision and the toggle that continues a comma run. The case is provoked by placing a comma right after a run ends, at spacings of one, two and several slots, and at both clock parities. In each case the bench predicts whether `clkOutP` holds or toggles from the words it drove. The same midpoint is also hit by a change of `splitRate` while a leading comma is pending. After such a change, the level of `clkOutP` in every half slot is judged against the rule for the mode that governs that slot.

// File: rtl/rbcgen_pkg.sv
package rbcgen_pkg;

  typedef enum logic {
    RATE_WORD  = 1'b0,
    RATE_SPLIT = 1'b1
  } rateSel_e;

  typedef struct packed {
    logic slotEdge;
    logic midEdge;
  } slotStrobe_t;

endpackage

// File: rtl/rbcgen_datapath.sv
module rbcgen_datapath
  import rbcgen_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int PIPE_DEPTH = 8,
  parameter int MARK_W = 7,
  parameter logic [MARK_W-1:0] COMMA_PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rst,
  input  slotStrobe_t       strobe,
  input  logic [WORD_W-1:0] rxWord,
  input  logic              rxValid,
  input  logic              commaDetEn,
  output logic [WORD_W-1:0] dataOut,
  output logic              commaFlag,
  output logic              curComma,
  output logic              nextComma
);

  localparam int LAST = PIPE_DEPTH - 1;
  localparam int PEEK = PIPE_DEPTH - 2;

  logic [WORD_W-1:0] wordPipe [PIPE_DEPTH];
  logic              markPipe [PIPE_DEPTH];
  logic              markIn;

  // Both polarities of the comma pattern, on valid words only.
  assign markIn = rxValid &&
                  ((rxWord[MARK_W-1:0] == COMMA_PAT) ||
                   (rxWord[MARK_W-1:0] == ~COMMA_PAT));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < PIPE_DEPTH; s++) begin
        wordPipe[s] <= '0;
        markPipe[s] <= 1'b0;
      end
    end else if (strobe.slotEdge) begin
      wordPipe[0] <= rxWord;
      markPipe[0] <= markIn;
      for (int s = 1; s < PIPE_DEPTH; s++) begin
        wordPipe[s] <= wordPipe[s-1];
        markPipe[s] <= markPipe[s-1];
      end
    end
  end

  assign dataOut   = wordPipe[LAST];
  assign curComma  = markPipe[LAST];
  assign nextComma = markPipe[PEEK];
  assign commaFlag = commaDetEn & curComma;

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.midEdge |=> $stable(dataOut));

  // R9
  run_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.slotEdge && nextComma) |=> curComma);

endmodule

// File: rtl/rbcgen_ctrl.sv
module rbcgen_ctrl
  import rbcgen_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        splitRate,
  input  logic        curComma,
  input  logic        nextComma,
  output slotStrobe_t strobe,
  output logic        clkOutP,
  output logic        clkOutN
);

  logic     phase;
  logic     stretch;
  logic     levelNext;
  rateSel_e rateSel;

  assign rateSel = rateSel_e'(splitRate);

  // phase 0: first half of a slot, phase 1: second half
  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end

  always_comb begin
    strobe.slotEdge = phase;
    strobe.midEdge  = ~phase;
  end

  // Hold one extra word period so the coming leading comma meets a rise.
  assign stretch = (rateSel == RATE_SPLIT) && !clkOutP && nextComma && !curComma;

  always_comb begin
    levelNext = clkOutP;
    if (strobe.midEdge) begin
      if (rateSel == RATE_SPLIT) levelNext = stretch ? clkOutP : ~clkOutP;
      else                       levelNext = 1'b1;
    end else if (rateSel == RATE_WORD) begin
      levelNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clkOutP <= 1'b0;
      clkOutN <= 1'b1;
    end else begin
      clkOutP <= levelNext;
      clkOutN <= ~levelNext;
    end
  end

  // R4
  word_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!phase && !splitRate) |=> clkOutP);

  // R4
  word_low_chk: assert property (@(posedge clk) disable iff (rst)
    (phase && !splitRate) |=> !clkOutP);

  // R5
  complement_chk: assert property (@(posedge clk) disable iff (rst)
    clkOutN != clkOutP);

  // R6
  split_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (phase && splitRate) |=> $stable(clkOutP));

  // R8
  lead_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!phase && splitRate && $past(splitRate) && $past(splitRate, 2) &&
     curComma && !$past(curComma, 2)) |-> !clkOutP);

  // R8
  lead_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!phase && splitRate && $past(splitRate) && $past(splitRate, 2) &&
     curComma && !$past(curComma, 2)) |=> clkOutP);

  // R9
  run_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (!phase && splitRate && curComma && nextComma) |=> (clkOutP != $past(clkOutP)));

endmodule

// File: rtl/rx_byteclk_gen.sv
module rx_byteclk_gen
  import rbcgen_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int PIPE_DEPTH = 8,
  parameter int MARK_W = 7,
  parameter logic [MARK_W-1:0] COMMA_PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] rxWord,
  input  logic              rxValid,
  input  logic              commaDetEn,
  input  logic              splitRate,
  output logic [WORD_W-1:0] dataOut,
  output logic              commaFlag,
  output logic              clkOutP,
  output logic              clkOutN
);

  slotStrobe_t strobe;
  logic        curComma;
  logic        nextComma;

  rbcgen_datapath #(
    .WORD_W(WORD_W),
    .PIPE_DEPTH(PIPE_DEPTH),
    .MARK_W(MARK_W),
    .COMMA_PAT(COMMA_PAT)
  ) u_datapath (
    .clk(clk),
    .rst(rst),
    .strobe(strobe),
    .rxWord(rxWord),
    .rxValid(rxValid),
    .commaDetEn(commaDetEn),
    .dataOut(dataOut),
    .commaFlag(commaFlag),
    .curComma(curComma),
    .nextComma(nextComma)
  );

  rbcgen_ctrl u_ctrl (
    .clk(clk),
    .rst(rst),
    .splitRate(splitRate),
    .curComma(curComma),
    .nextComma(nextComma),
    .strobe(strobe),
    .clkOutP(clkOutP),
    .clkOutN(clkOutN)
  );

endmodule

// File: tb/rx_byteclk_gen_test.sv
module rx_byteclk_gen_test;

  localparam int PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int NSLOT  = 1500;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] rxWord = '0;
  logic       rxValid = 1'b0;
  logic       commaDetEn = 1'b1;
  logic       splitRate = 1'b1;
  logic [9:0] dataOut;
  logic       commaFlag;
  logic       clkOutP;
  logic       clkOutN;

  rx_byteclk_gen #(.PIPE_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .rxWord(rxWord), .rxValid(rxValid),
    .commaDetEn(commaDetEn), .splitRate(splitRate), .dataOut(dataOut),
    .commaFlag(commaFlag), .clkOutP(clkOutP), .clkOutN(clkOutN)
  );

  always #(PERIOD/2) clk = ~clk;

  logic [9:0] hist   [NSLOT];
  bit         vHist  [NSLOT];
  bit         modeAt [NSLOT];
  bit         detAt  [NSLOT];
  bit         mode0 = 1'b1;
  bit         det0  = 1'b1;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  int  runLeft = 0;
  bit  curMode = 1'b1;
  bit  curDet = 1'b1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit isMark(logic [9:0] w, bit v);
    return v && (w[6:0] == 7'b1111100 || w[6:0] == 7'b0000011);
  endfunction

  function automatic bit expMark(int k);
    if (k < DEPTH) return 1'b0;
    return isMark(hist[k-DEPTH], vHist[k-DEPTH]);
  endfunction

  function automatic logic [9:0] expWord(int k);
    if (k < DEPTH) return '0;
    return hist[k-DEPTH];
  endfunction

  function automatic bit modeOf(int k);
    return (k < 0) ? mode0 : modeAt[k];
  endfunction

  function automatic bit detOf(int k);
    return (k < 0) ? det0 : detAt[k];
  endfunction

  function automatic logic [9:0] commaWord(bit neg);
    logic [2:0] hi;
    hi = 3'($urandom());
    return neg ? {hi, 7'b0000011} : {hi, 7'b1111100};
  endfunction

  // Directed segments first, then constrained random.
  task automatic genStim(int n);
    logic [9:0] w;
    bit v;
    int r;
    w = 10'($urandom());
    v = 1'b1;
    if (n < 480) begin
      r = n % 24;
      case (n / 80)
        0, 1, 3, 5: curMode = 1'b1;
        default:    curMode = 1'b0;
      endcase
      if (r == 3) w = commaWord(1'b0);
      else if (r == 10) w = commaWord(1'b1);
      else if (r >= 15 && r <= 18) w = commaWord(r[0]);
      else if (r == 20) v = 1'b0;
      else if (r == 21) w = commaWord(1'b0);
      curDet = !((n % 97) >= 40 && (n % 97) <= 45);
    end else begin
      if (($urandom() % 40) == 0) curMode = !curMode;
      if (($urandom() % 20) == 0) curDet = !curDet;
      if (runLeft > 0) begin
        w = commaWord(1'($urandom()));
        runLeft--;
      end else if (($urandom() % 6) == 0) begin
        w = commaWord(1'($urandom()));
        if (($urandom() % 3) == 0) runLeft = 1 + int'($urandom() % 4);
      end
      if (($urandom() % 16) == 0) v = 1'b0;
    end
    hist[n] = w;
    vHist[n] = v;
    modeAt[n] = curMode;
    detAt[n] = curDet;
    rxWord = w;
    rxValid = v;
    splitRate = curMode;
    commaDetEn = curDet;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, errors);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    bit prevSecond;
    bit lastLevel;
    int runLen;
    void'($urandom(32'h5EED_2024));
    prevSecond = 1'b0;
    lastLevel = 1'b0;
    runLen = 0;
    splitRate = mode0;
    commaDetEn = det0;
    repeat (4) @(posedge clk);
    #1;
    // R1 during reset
    check(dataOut == 10'd0 && !commaFlag, "R1", "reset data/flag", int'(dataOut), 0);
    check(clkOutP == 1'b0 && clkOutN == 1'b1, "R1", "reset clocks", int'({clkOutP, clkOutN}), 1);
    @(negedge clk);
    rst = 1'b0;
    for (int n = 0; n < NSLOT; n++) begin
      bit m, expFirst, expSecond, hold, aFirst, aSecond, expFlag;
      string tagC;
      m = modeOf(n - 1);
      expFirst = (n == 0) ? 1'b0 : (m ? prevSecond : 1'b0);
      hold = m && !expFirst && expMark(n + 1) && !expMark(n);
      expSecond = !m ? 1'b1 : (hold ? expFirst : !expFirst);
      expFlag = detOf(n - 1) && expMark(n);
      if (n == 0) tagC = "R1";
      else if (modeOf(n - 1) != modeOf(n - 2)) tagC = "R11";
      else if (!m) tagC = "R4";
      else if (hold) tagC = "R7";
      else tagC = "R6";

      // first half of slot n
      aFirst = clkOutP;
      check(dataOut == expWord(n), (n == 0) ? "R1" : "R3", "dataOut", int'(dataOut), int'(expWord(n)));
      check(commaFlag == expFlag, (n == 0) ? "R1" : "R2", "commaFlag first half", int'(commaFlag), int'(expFlag));
      check(clkOutP == expFirst, tagC, "clkOutP first half", int'(clkOutP), int'(expFirst));
      check(clkOutN == !clkOutP, "R5", "clkOutN first half", int'(clkOutN), int'(!clkOutP));
      if (clkOutP == lastLevel) runLen++;
      else begin
        if (n >= 3 && modeOf(n - 1) && modeOf(n - 2) && modeOf(n - 3))
          check(runLen >= 2, "R10", "level length", runLen, 2);
        lastLevel = clkOutP;
        runLen = 1;
      end

      @(posedge clk);
      @(negedge clk);
      // second half of slot n
      aSecond = clkOutP;
      check(clkOutP == expSecond, tagC, "clkOutP second half", int'(clkOutP), int'(expSecond));
      check(clkOutN == !clkOutP, "R5", "clkOutN second half", int'(clkOutN), int'(!clkOutP));
      check(dataOut == expWord(n), "R3", "dataOut stable in slot", int'(dataOut), int'(expWord(n)));
      if (n >= 1 && m && modeOf(n - 2) && expMark(n) && !expMark(n - 1))
        check(!aFirst && aSecond, "R8", "leading comma on rise", int'({aFirst, aSecond}), 1);
      if (m && expMark(n) && expMark(n - 1)) begin
        check(aSecond != aFirst, "R9", "toggle inside comma run", int'(aSecond), int'(!aFirst));
        check(commaFlag == detOf(n - 1), "R9", "flag inside comma run", int'(commaFlag), int'(detOf(n - 1)));
      end
      if (clkOutP == lastLevel) runLen++;
      else begin
        if (n >= 3 && modeOf(n - 1) && modeOf(n - 2) && modeOf(n - 3))
          check(runLen >= 2, "R10", "level length", runLen, 2);
        lastLevel = clkOutP;
        runLen = 1;
      end
      prevSecond = expSecond;

      genStim(n);
      @(posedge clk);
      @(negedge clk);
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule